// File: doc/BRIEF.md
# Card Data FIFO with Byte Packing

This block buffers data words between a host data port and a byte-wide card data stream. A 16-entry ring of 32-bit words sits in the middle. In receive mode, card bytes are gathered four at a time into a word, lowest byte first, and the word is pushed into the ring for the host to read. In transmit mode, the host writes words and the block breaks each one into bytes, again lowest byte first, for the card side.

A transfer starts with a one-cycle start pulse. The pulse carries a 16-bit length in bytes and a direction bit. The block keeps two countdowns. The first counts the bytes still to move on the card side. The second counts the host accesses still expected, which is the byte length rounded up to whole words. When both countdowns reach zero, the transfer switches itself off.

The control is a three-state machine. IDLE means no transfer is active. MOVE means card bytes remain to be transferred. DRAIN means every card byte has moved but host reads are still owed.

The transitions are:
- IDLE to MOVE on a start with a nonzero length.
- MOVE to DRAIN when the byte countdown reaches zero while host accesses remain.
- MOVE or DRAIN to IDLE when both countdowns are zero.
- Any state to IDLE on a start with zero length.
- MOVE or DRAIN to MOVE on a start with a nonzero length, which restarts the transfer.

A start also empties the ring and resets the byte lane. Status flags are derived from the ring occupancy. Only the flag group that matches the current direction is reported.

Top module: `card_fifo_packer`

## Requirements
- R1: After reset, xfer_en, data_end, block_end, card_rx_ready, card_tx_valid and every FIFO flag are 0, and host_rdata is 0.
- R2: A start pulse loads the byte countdown with xfer_len and the host word countdown with (xfer_len+3)/4. A zero length leaves xfer_en at 0.
- R3: In receive mode, card byte number i of the transfer lands in bits 8*(i mod 4)+7 : 8*(i mod 4) of host word i/4. Host words come out in arrival order. If the transfer ends on a partly filled word, that word is still delivered, with its unfilled upper bytes equal to 0.
- R4: In transmit mode, each host word is sent as bytes from bits 7:0 upward. Only xfer_len bytes are sent in total, so the unused upper bytes of a final partial word are dropped.
- R5: An effective host access decrements the word countdown by one. In receive mode the effective access is a read; in transmit mode it is a write. Accesses in the other direction are ignored. Any access while the countdown is 0 is ignored. host_rdata reads as 0 whenever the countdown is 0 or the mode is transmit.
- R6: data_end and block_end rise when the byte countdown reaches 0, or immediately on a zero-length start. They hold until the next start.
- R7: xfer_en drops when both countdowns are 0. While xfer_en is 0, all FIFO flags are 0.
- R8: While xfer_en is 1 and the ring holds c words:
  - empty is 1 when c = 0.
  - avail is 1 when c > 0.
  - full is 1 when c = 16.
  - tx_half_empty is 1 when c <= 8.
  - rx_half_full is 1 when c >= 8.
  - The active flag of the current direction is 1.
- R9: In receive mode every tx_* flag is 0, and in transmit mode every rx_* flag is 0.
- R10: The ring never pushes when full or pops when empty. card_rx_ready is 0 while the ring is full, and card_tx_valid is 0 while it is empty. Card traffic resumes once space or data appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle pulse that starts a transfer |
| xfer_len | input | 16 | Transfer length in bytes, sampled on start |
| xfer_dir_rx | input | 1 | 1 = receive (card to host), 0 = transmit, sampled on start |
| host_wr | input | 1 | Host write strobe on the data port |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe on the data port |
| host_rdata | output | 32 | Head word of the ring when a read is allowed, otherwise 0 |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_byte | input | 8 | Received byte |
| card_rx_ready | output | 1 | Block accepts a received byte |
| card_tx_valid | output | 1 | Block offers a byte to send |
| card_tx_byte | output | 8 | Byte to send |
| card_tx_ready | input | 1 | Card takes the offered byte |
| xfer_en | output | 1 | Transfer active (state is not IDLE) |
| data_end | output | 1 | Byte countdown has reached zero |
| block_end | output | 1 | Block completed; same timing as data_end |
| rx_active | output | 1 | Receive transfer active |
| rx_empty | output | 1 | Receive ring empty |
| rx_avail | output | 1 | Receive ring holds data |
| rx_half_full | output | 1 | Receive ring holds at least half its depth |
| rx_full | output | 1 | Receive ring full |
| tx_active | output | 1 | Transmit transfer active |
| tx_empty | output | 1 | Transmit ring empty |
| tx_avail | output | 1 | Transmit ring holds data |
| tx_half_empty | output | 1 | Transmit ring holds at most half its depth |
| tx_full | output | 1 | Transmit ring full |

## Verification
Internal faults in this block show up at the ports in predictable ways:
- A wrong byte-lane index shows up as a byte in the wrong lane. In receive mode this is visible on the first host read of the affected word; in transmit mode it is visible on the next card byte.
- An off-by-one in either countdown moves the cycle where xfer_en falls. It falls one access early, or never falls. The fault is visible at the last expected access.
- A slip in a ring pointer or the occupancy count appears as reordered words, or as a flag that changes at the wrong occupancy. The flags are combinational from registered state, so they show such a fault one clock after the push or pop that caused it.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_MOVE  = 2'd1,
        XF_DRAIN = 2'd2
    } xf_state_e;
endpackage

// File: rtl/cfp_ring.sv
module cfp_ring #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign push_ok   = push && (count != CW'(DEPTH)) && !flush;
    assign pop_ok    = pop && (count != '0) && !flush;
    assign head_data = mem[rd_ptr];

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/cfp_lane.sv
module cfp_lane #(
    parameter int WIDTH = 32,
    localparam int BPW = WIDTH / 8,
    localparam int IW  = $clog2(BPW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             last,
    input  logic [7:0]       in_byte,
    output logic [IW-1:0]    idx,
    output logic [WIDTH-1:0] packed_word,
    output logic             word_done
);
    logic [WIDTH-1:0] acc;

    always_comb begin
        packed_word = acc;
        packed_word[{idx, 3'b000} +: 8] = in_byte;
    end

    assign word_done = step && ((idx == IW'(BPW - 1)) || last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clear || word_done) begin
            acc <= '0;
            idx <= '0;
        end else if (step) begin
            acc <= packed_word;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfp_flags.sv
module cfp_flags #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          active,
    input  logic          dir_rx,
    input  logic [CW-1:0] count,
    output logic          rx_active,
    output logic          rx_empty,
    output logic          rx_avail,
    output logic          rx_half_full,
    output logic          rx_full,
    output logic          tx_active,
    output logic          tx_empty,
    output logic          tx_avail,
    output logic          tx_half_empty,
    output logic          tx_full
);
    logic rx_on, tx_on, is_empty, is_full;

    assign rx_on    = active && dir_rx;
    assign tx_on    = active && !dir_rx;
    assign is_empty = (count == '0);
    assign is_full  = (count == CW'(DEPTH));

    assign rx_active     = rx_on;
    assign rx_empty      = rx_on && is_empty;
    assign rx_avail      = rx_on && !is_empty;
    assign rx_half_full  = rx_on && (count >= CW'(DEPTH / 2));
    assign rx_full       = rx_on && is_full;
    assign tx_active     = tx_on;
    assign tx_empty      = tx_on && is_empty;
    assign tx_avail      = tx_on && !is_empty;
    assign tx_half_empty = tx_on && (count <= CW'(DEPTH / 2));
    assign tx_full       = tx_on && is_full;
endmodule

// File: rtl/card_fifo_packer.sv
module card_fifo_packer
    import card_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LEN_W = 16,
    localparam int BPW = WIDTH / 8,
    localparam int IW  = $clog2(BPW),
    localparam int CW  = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_dir_rx,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             card_rx_valid,
    input  logic [7:0]       card_rx_byte,
    output logic             card_rx_ready,
    output logic             card_tx_valid,
    output logic [7:0]       card_tx_byte,
    input  logic             card_tx_ready,
    output logic             xfer_en,
    output logic             data_end,
    output logic             block_end,
    output logic             rx_active,
    output logic             rx_empty,
    output logic             rx_avail,
    output logic             rx_half_full,
    output logic             rx_full,
    output logic             tx_active,
    output logic             tx_empty,
    output logic             tx_avail,
    output logic             tx_half_empty,
    output logic             tx_full
);
    xf_state_e        state_q, state_d;
    logic [LEN_W-1:0] byte_cnt_q, byte_cnt_d;
    logic [LEN_W-1:0] host_cnt_q, host_cnt_d;
    logic             done_q, done_d;
    logic             dir_q;
    logic [LEN_W:0]   len_round;
    logic [CW-1:0]    fifo_cnt;
    logic [WIDTH-1:0] head_data, packed_word;
    logic [IW-1:0]    lane_idx;
    logic             word_done, card_move, host_ok, ring_push, ring_pop;
    logic [WIDTH-1:0] ring_wdata;

    assign len_round = {1'b0, xfer_len} + (LEN_W + 1)'(BPW - 1);

    // Datapath strobes
    assign card_move = !xfer_start && (dir_q ? (card_rx_valid && card_rx_ready)
                                             : (card_tx_valid && card_tx_ready));
    assign host_ok   = !xfer_start && (host_cnt_q != '0) && (dir_q ? host_rd : host_wr);
    assign ring_push  = dir_q ? (card_move && word_done) : host_ok;
    assign ring_pop   = dir_q ? host_ok : (card_move && word_done);
    assign ring_wdata = dir_q ? packed_word : host_wdata;

    cfp_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(xfer_start),
        .push(ring_push), .wdata(ring_wdata), .pop(ring_pop),
        .head_data(head_data), .count(fifo_cnt)
    );

    cfp_lane #(.WIDTH(WIDTH)) u_lane (
        .clk(clk), .rst_n(rst_n), .clear(xfer_start),
        .step(card_move), .last(byte_cnt_q == LEN_W'(1)),
        .in_byte(dir_q ? card_rx_byte : 8'h00),
        .idx(lane_idx), .packed_word(packed_word), .word_done(word_done)
    );

    cfp_flags #(.DEPTH(DEPTH)) u_flags (
        .active(xfer_en), .dir_rx(dir_q), .count(fifo_cnt),
        .rx_active(rx_active), .rx_empty(rx_empty), .rx_avail(rx_avail),
        .rx_half_full(rx_half_full), .rx_full(rx_full),
        .tx_active(tx_active), .tx_empty(tx_empty), .tx_avail(tx_avail),
        .tx_half_empty(tx_half_empty), .tx_full(tx_full)
    );

    // Countdowns and next state
    always_comb begin
        if (xfer_start) begin
            byte_cnt_d = xfer_len;
            host_cnt_d = LEN_W'(len_round >> IW);
            done_d     = (xfer_len == '0);
        end else begin
            byte_cnt_d = byte_cnt_q - LEN_W'(card_move);
            host_cnt_d = host_cnt_q - LEN_W'(host_ok);
            done_d     = done_q || (card_move && (byte_cnt_q == LEN_W'(1)));
        end
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (xfer_start && (xfer_len != '0)) state_d = XF_MOVE;
            end
            XF_MOVE, XF_DRAIN: begin
                if (xfer_start)
                    state_d = (xfer_len != '0) ? XF_MOVE : XF_IDLE;
                else if ((byte_cnt_d == '0) && (host_cnt_d == '0))
                    state_d = XF_IDLE;
                else if (byte_cnt_d == '0)
                    state_d = XF_DRAIN;
            end
            default: state_d = XF_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= XF_IDLE;
            byte_cnt_q <= '0;
            host_cnt_q <= '0;
            done_q     <= 1'b0;
            dir_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            byte_cnt_q <= byte_cnt_d;
            host_cnt_q <= host_cnt_d;
            done_q     <= done_d;
            if (xfer_start) dir_q <= xfer_dir_rx;
        end
    end

    // Outputs
    always_comb begin
        xfer_en       = (state_q != XF_IDLE);
        card_rx_ready = (state_q == XF_MOVE) && dir_q && (fifo_cnt != CW'(DEPTH));
        card_tx_valid = (state_q == XF_MOVE) && !dir_q && (fifo_cnt != '0);
        card_tx_byte  = head_data[{lane_idx, 3'b000} +: 8];
        host_rdata    = (dir_q && (host_cnt_q != '0) && (fifo_cnt != '0)) ? head_data : '0;
        data_end      = done_q;
        block_end     = done_q;
    end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LEN_W = 16,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int IW = $clog2(WIDTH / 8)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic [LEN_W-1:0] xfer_len,
    input logic             xfer_en,
    input logic             data_end,
    input logic [WIDTH-1:0] host_rdata,
    input logic             card_rx_ready,
    input logic             card_tx_valid,
    input logic             rx_active,
    input logic             tx_active,
    input logic             rx_full,
    input logic             tx_empty,
    input logic             rx_avail,
    input logic             tx_avail,
    input logic [CW-1:0]    fifo_cnt,
    input logic [LEN_W-1:0] host_cnt_q,
    input logic [LEN_W-1:0] byte_cnt_q
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_cnt <= CW'(DEPTH)); // R10
    AST_RX_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n) rx_full |-> !card_rx_ready); // R10
    AST_TX_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_empty |-> !card_tx_valid); // R10
    AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rx_active, tx_active})); // R9
    AST_LOAD_WORDS: assert property (@(posedge clk) disable iff (!rst_n) xfer_start |=> host_cnt_q == LEN_W'(({1'b0, $past(xfer_len)} + (LEN_W + 1)'((1 << IW) - 1)) >> IW)); // R2
    AST_LOAD_BYTES: assert property (@(posedge clk) disable iff (!rst_n) xfer_start |=> byte_cnt_q == $past(xfer_len)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !xfer_en |-> !(rx_active || tx_active || rx_avail || tx_avail)); // R7
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n) (host_cnt_q == '0) |-> (host_rdata == '0)); // R5
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (xfer_en && byte_cnt_q == '0) |-> data_end); // R6
endmodule

bind card_fifo_packer cfp_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .xfer_en(xfer_en), .data_end(data_end), .host_rdata(host_rdata),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .rx_active(rx_active), .tx_active(tx_active), .rx_full(rx_full),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .tx_avail(tx_avail),
    .fifo_cnt(fifo_cnt), .host_cnt_q(host_cnt_q), .byte_cnt_q(byte_cnt_q)
);

// File: tb/sim_card_fifo_packer.sv
module sim_card_fifo_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        xfer_dir_rx = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_byte = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_byte;
    logic        card_tx_ready = 1'b0;
    logic        xfer_en, data_end, block_end;
    logic        rx_active, rx_empty, rx_avail, rx_half_full, rx_full;
    logic        tx_active, tx_empty, tx_avail, tx_half_empty, tx_full;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int sent, got, wrn, hw_exp;
    logic [7:0] bytes_a [0:255];

    always #10 clk = ~clk;

    card_fifo_packer u0 (.*);

    wire [4:0] rx_flags = {rx_active, rx_empty, rx_avail, rx_half_full, rx_full};
    wire [4:0] tx_flags = {tx_active, tx_empty, tx_avail, tx_half_empty, tx_full};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k, input int len);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++)
            if (4 * k + j < len) w[8*j +: 8] = bytes_a[4*k+j];
        return w;
    endfunction

    function automatic logic [31:0] full_word(input int k);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[8*j +: 8] = bytes_a[(4*k+j) & 255];
        return w;
    endfunction

    task automatic fill_bytes();
        for (int i = 0; i < 256; i++) bytes_a[i] = 8'($urandom);
    endtask

    task automatic start_xfer(input int len, input bit dir);
        xfer_start = 1'b1; xfer_len = 16'(len); xfer_dir_rx = dir;
        @(negedge clk);
        xfer_start = 1'b0;
        sent = 0; got = 0; wrn = 0; hw_exp = (len + 3) / 4;
    endtask

    task automatic rx_loop(input int len, input int pv, input int pr, input int lim);
        int cyc = 0;
        bit acc, rd;
        while (xfer_en && cyc < lim) begin
            card_rx_valid = (sent < len) && (int'($urandom % 100) < pv);
            card_rx_byte  = bytes_a[sent & 255];
            rd = rx_avail && (got < hw_exp) && (int'($urandom % 100) < pr);
            host_rd = rd;
            #1;
            if (rd) check("R3 rx word", host_rdata, exp_word(got, len));
            acc = card_rx_valid && card_rx_ready;
            @(negedge clk);
            if (acc) sent++;
            if (rd) got++;
            cyc++;
        end
        card_rx_valid = 1'b0; host_rd = 1'b0;
    endtask

    task automatic tx_loop(input int len, input int pw, input int pr, input int lim);
        int cyc = 0;
        bit acc, wr;
        while (xfer_en && cyc < lim) begin
            wr = (wrn < hw_exp) && !tx_full && (int'($urandom % 100) < pw);
            host_wr = wr;
            host_wdata = full_word(wrn);
            card_tx_ready = (int'($urandom % 100) < pr);
            #1;
            acc = card_tx_valid && card_tx_ready;
            if (acc) check("R4 tx byte", 32'(card_tx_byte), 32'(bytes_a[sent & 255]));
            @(negedge clk);
            if (acc) sent++;
            if (wr) wrn++;
            cyc++;
        end
        host_wr = 1'b0; card_tx_ready = 1'b0;
    endtask

    task automatic finish_checks(input int len, input bit is_rx);
        check("R7 xfer_en off", 32'(xfer_en), 32'd0);
        check("R6 data_end", 32'(data_end), 32'd1);
        check("R6 block_end", 32'(block_end), 32'd1);
        check(is_rx ? "R3 byte total" : "R4 byte total", sent, len);
        check("R5 host access total", is_rx ? got : wrn, hw_exp);
        check("R7 flags dropped", 32'({rx_flags, tx_flags}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        bit acc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 xfer_en", 32'(xfer_en), 0);
        check("R1 done flags", 32'({data_end, block_end}), 0);
        check("R1 card handshake", 32'({card_rx_ready, card_tx_valid}), 0);
        check("R1 flags", 32'({rx_flags, tx_flags}), 0);
        check("R1 rdata", host_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6 zero length
        start_xfer(0, 1'b1);
        check("R2 zero len stays idle", 32'(xfer_en), 0);
        check("R6 zero len done", 32'({data_end, block_end}), 32'h3);

        // R3 partial word, full speed
        fill_bytes();
        start_xfer(5, 1'b1);
        check("R6 done cleared by start", 32'(data_end), 0);
        rx_loop(5, 100, 100, 200);
        finish_checks(5, 1'b1);

        // R8 / R9 / R10 receive thresholds and stall
        fill_bytes();
        start_xfer(68, 1'b1);
        for (int i = 0; i < 64; i++) begin
            card_rx_valid = 1'b1; card_rx_byte = bytes_a[sent];
            #1; acc = card_rx_ready;
            @(negedge clk);
            if (acc) sent++;
            c = sent / 4;
            check("R8 rx flags", 32'(rx_flags),
                  32'({1'b1, c == 0, c != 0, c >= 8, c == 16}));
            check("R9 tx masked", 32'(tx_flags), 0);
        end
        for (int i = 0; i < 3; i++) begin
            card_rx_byte = bytes_a[sent];
            #1; check("R10 rx stall when full", 32'(card_rx_ready), 0);
            @(negedge clk);
        end
        card_rx_valid = 1'b0;
        rx_loop(68, 70, 60, 3000);
        finish_checks(68, 1'b1);

        // R8 / R9 / R10 transmit thresholds
        fill_bytes();
        start_xfer(72, 1'b0);
        card_tx_ready = 1'b0;
        check("R10 tx no byte when empty", 32'(card_tx_valid), 0);
        for (int i = 0; i < 16; i++) begin
            host_wr = 1'b1; host_wdata = full_word(wrn);
            @(negedge clk);
            host_wr = 1'b0;
            wrn++;
            c = wrn;
            check("R8 tx flags", 32'(tx_flags),
                  32'({1'b1, c == 0, c != 0, c <= 8, c == 16}));
            check("R9 rx masked", 32'(rx_flags), 0);
        end
        tx_loop(72, 80, 70, 3000);
        finish_checks(72, 1'b0);

        // R5 wrong-direction write and access with zero countdown
        fill_bytes();
        start_xfer(8, 1'b1);
        rx_loop(8, 100, 0, 10);
        check("R3 bytes in", sent, 8);
        host_wr = 1'b1; host_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        host_wr = 1'b0;
        check("R5 write ignored in rx", 32'(xfer_en), 1);
        host_rd = 1'b1; #1;
        check("R3 word0", host_rdata, exp_word(0, 8));
        @(negedge clk);
        check("R5 one read left", 32'(xfer_en), 1);
        #1;
        check("R3 word1", host_rdata, exp_word(1, 8));
        @(negedge clk);
        host_rd = 1'b0;
        check("R7 ends after last read", 32'(xfer_en), 0);
        host_rd = 1'b1; #1;
        check("R5 read at zero count", host_rdata, 0);
        @(negedge clk);
        host_rd = 1'b0;
        check("R5 read at zero ignored", 32'({xfer_en, rx_flags, tx_flags}), 0);

        // random transfers
        for (int it = 0; it < 6; it++) begin
            int len;
            fill_bytes();
            len = 1 + int'($urandom % 150);
            start_xfer(len, 1'b1);
            rx_loop(len, 30 + int'($urandom % 70), 30 + int'($urandom % 70), 20000);
            finish_checks(len, 1'b1);
            fill_bytes();
            len = 1 + int'($urandom % 150);
            start_xfer(len, 1'b0);
            tx_loop(len, 30 + int'($urandom % 70), 30 + int'($urandom % 70), 20000);
            finish_checks(len, 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule